// File: doc/BRIEF.md
# Host Bus Command and Sound-Data Port

This block is the host-facing bus port of a sound playback controller. An external controller drives a chip select, active-low write and read strobes and a data/command select. The port brings these asynchronous strobes into the core clock domain and finds the trailing edge of each write or read pulse. It then sends the transfer to one of two places. With the select high, the transfer goes to the sound-data write path. With the select low, it goes to an 8-bit command register. Reads return sound data when the select is high and a status byte on the low lanes when it is low.

A strap input sets the bus width. With the strap high (wide mode), all 16 lanes carry sound data in both directions. With the strap low (narrow mode), only the low byte talks to the host. The upper byte then becomes a general I/O port toward external memory. Commands set whether that port is an input or an output and set the value it drives. After each accepted command, the port reports itself busy for a fixed number of core clocks.

The data bus is split into an input vector, an output vector and one output enable per byte lane. The pad ring builds the tri-state pins from these.

Top module: `hostbus_port`

## Requirements
- R1: While `cs_n` is high, write and read strobes are ignored: no command, sound write or read pop results, and `bus_oe_lo` stays low.
- R2: A write with `dc_sel` low produces exactly one `cmd_valid` pulse, carrying the low byte of the bus, 3 core clocks after the rising edge of `wr_n`. The upper byte of the bus does not affect the command.
- R3: A write with `dc_sel` high produces exactly one `snd_wr_valid` pulse. In wide mode it carries all 16 bits. In narrow mode it carries the low byte with the upper byte zero. A single write never produces both a command and a sound write.
- R4: `bus_oe_lo` is high exactly while `cs_n` and `rd_n` are both low. In wide mode `bus_oe_hi` is high exactly while `bus_oe_lo` and `dc_sel` are high. During a data read, `bus_out` carries `snd_rd_data`.
- R5: During a read with `dc_sel` low, `bus_out[7:0]` is the status byte: bit 0 is `cmd_busy` and bits 7:1 are `status_in[6:0]`.
- R6: After an accepted command, `cmd_busy` is high for exactly `BUSY_CYCLES` clocks, starting in the cycle of `cmd_valid`. A command write whose trailing edge is detected while busy is dropped.
- R7: In narrow mode the upper-lane direction resets to output, so `bus_oe_hi` is high. Command 0xA1 makes the upper lanes inputs (`bus_oe_hi` low). Command 0xA0 makes them outputs again. The direction applies only in narrow mode.
- R8: Command 0xCn loads bits 3:0 of the upper-port value with n, and command 0xDn loads bits 7:4 with n. In narrow mode `bus_out[15:8]` shows this value. When the upper lanes are inputs, `xport_rd` shows `bus_in[15:8]` after synchronisation; otherwise it is zero.
- R9: A read with `dc_sel` high produces exactly one `snd_rd_pop` pulse after the rising edge of `rd_n`. A status read produces none.
- R10: After reset, every pulse output is low, `cmd_busy` is low, the upper-port value is zero and the upper lanes are outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 = 16-bit host bus, 0 = 8-bit host bus with an upper I/O port |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| dc_sel | input | 1 | 1 = sound data, 0 = command/status |
| bus_in | input | 16 | Data bus as seen at the pins |
| bus_out | output | 16 | Data driven toward the pins |
| bus_oe_lo | output | 1 | Output enable for lanes 7:0 |
| bus_oe_hi | output | 1 | Output enable for lanes 15:8 |
| status_in | input | 7 | Core status flags, placed in bits 7:1 of the status byte |
| snd_rd_data | input | 16 | Sound data offered for host reads |
| cmd_valid | output | 1 | One-cycle pulse: a new command byte |
| cmd_data | output | 8 | Command byte, valid with `cmd_valid` |
| cmd_busy | output | 1 | High while no new command is accepted |
| snd_wr_valid | output | 1 | One-cycle pulse: a new sound-data word |
| snd_wr_data | output | 16 | Sound-data word, valid with `snd_wr_valid` |
| snd_rd_pop | output | 1 | One-cycle pulse: a host data read has finished |
| xport_rd | output | 8 | Upper-lane input value in narrow input mode, else zero |

## Verification
The bench aims at edge counting across the synchroniser. A design that fires on the falling edge, or on every cycle the strobe is low, would give several pulses per write or the wrong data, and the bench counts pulses in a fixed window after each strobe. It drives full strobes with chip select high. A gate in the wrong place would let a command or a pop through, or turn on the low-lane drivers. It sends a second command inside the busy window; a design that does not drop it gives a second `cmd_valid`. It also walks the narrow-mode port through direction and nibble commands. A design with the wrong default direction, or one that lets the direction act in wide mode, would show a wrong `bus_oe_hi` or a wrong upper byte.

// File: rtl/hostbus_pkg.sv
// Shared widths and command encodings for the host bus port.
// Assumes a 16-bit host bus made of two byte lanes.
package hostbus_pkg;
    localparam int BYTE_W = 8;
    localparam int HOST_W = 2 * BYTE_W;
    localparam int NIB_W  = BYTE_W / 2;

    // Upper nibble of a command byte that configures the upper I/O port
    typedef enum logic [NIB_W-1:0] {
        OPC_DIR  = 4'hA,   // arg bit0: 1 = upper lanes input, 0 = output
        OPC_PLO  = 4'hC,   // arg -> port value bits 3:0
        OPC_PHI  = 4'hD    // arg -> port value bits 7:4
    } cfg_op_e;
endpackage

// File: rtl/hostbus_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is sampled on its own; a vector that changes at once
// may skew by one cycle between bits, so callers hold data stable.
module hostbus_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift the input one flop further down the chain
            always_ff @(posedge clk) begin
                if (!rst_n)       stage_q[gi] <= RST_VAL;
                else if (gi == 0) stage_q[gi] <= d;
                else              stage_q[gi] <= stage_q[(gi > 0) ? gi - 1 : 0];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hostbus_strobe.sv
// Trailing-edge detector for one synchronised active-low strobe.
// Latches chip select and a side-band vector on every cycle the strobe is low,
// so the fire pulse carries the values seen during the pulse.
// Assumes the strobe is already synchronised to clk.
module hostbus_strobe #(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strb_s,
    input  logic          cs_s,
    input  logic [DW-1:0] data_s,
    output logic          fire,
    output logic [DW-1:0] data_hold
);
    logic strb_prev;
    logic cs_hold;

    // Remember last cycle's strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strb_prev <= 1'b1;
        else        strb_prev <= strb_s;
    end

    // Capture chip select and data while the strobe is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_hold   <= 1'b1;
            data_hold <= '0;
        end else if (!strb_s) begin
            cs_hold   <= cs_s;
            data_hold <= data_s;
        end
    end

    assign fire = strb_s && !strb_prev && !cs_hold;
endmodule

// File: rtl/hostbus_cfg.sv
// Command-side state: busy timer and upper I/O port configuration.
// Assumes cmd_fire is already qualified by not-busy.
module hostbus_cfg import hostbus_pkg::*; #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              busy,
    output logic              port_dir_in,
    output logic [BYTE_W-1:0] port_val
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] busy_cnt;
    logic [NIB_W-1:0] op_code;
    logic [NIB_W-1:0] op_arg;

    assign op_code = cmd_byte[BYTE_W-1:NIB_W];
    assign op_arg  = cmd_byte[NIB_W-1:0];

    // Load the busy timer on each command and count it down
    always_ff @(posedge clk) begin
        if (!rst_n)              busy_cnt <= '0;
        else if (cmd_fire)       busy_cnt <= CNT_W'(BUSY_CYCLES);
        else if (busy_cnt != 0)  busy_cnt <= busy_cnt - 1'b1;
    end

    assign busy = (busy_cnt != 0);

    // Decode port configuration commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_dir_in <= 1'b0;
            port_val    <= '0;
        end else if (cmd_fire) begin
            case (op_code)
                OPC_DIR: port_dir_in           <= op_arg[0];
                OPC_PLO: port_val[NIB_W-1:0]   <= op_arg;
                OPC_PHI: port_val[BYTE_W-1:NIB_W] <= op_arg;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hostbus_port.sv
// Host bus port: synchronises cs/wr/rd/dc, routes writes to the command
// or sound-data path, and drives read data or status onto the bus.
// Assumes the host holds dc_sel, cs_n and bus_in stable for the strobe
// pulse, and each strobe level lasts at least one core clock.
module hostbus_port import hostbus_pkg::*; #(
    parameter int BUSY_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              dc_sel,
    input  logic [HOST_W-1:0] bus_in,
    output logic [HOST_W-1:0] bus_out,
    output logic              bus_oe_lo,
    output logic              bus_oe_hi,
    input  logic [BYTE_W-2:0] status_in,
    input  logic [HOST_W-1:0] snd_rd_data,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_busy,
    output logic              snd_wr_valid,
    output logic [HOST_W-1:0] snd_wr_data,
    output logic              snd_rd_pop,
    output logic [BYTE_W-1:0] xport_rd
);
    localparam int CTL_W = 4;   // {dc, rd, wr, cs}
    localparam int WH_W  = HOST_W + 1;

    logic [CTL_W-1:0]  ctl_s;
    logic [HOST_W-1:0] bus_s;
    logic              wr_fire, rd_fire;
    logic [WH_W-1:0]   wr_hold;
    logic [0:0]        rd_hold;
    logic              cmd_fire, snd_fire;
    logic              port_dir_in;
    logic [BYTE_W-1:0] port_val;

    hostbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({dc_sel, rd_n, wr_n, cs_n}), .q(ctl_s)
    );

    hostbus_sync #(.W(HOST_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s)
    );

    hostbus_strobe #(.DW(WH_W)) u_wr_edge (
        .clk(clk), .rst_n(rst_n), .strb_s(ctl_s[1]), .cs_s(ctl_s[0]),
        .data_s({ctl_s[3], bus_s}), .fire(wr_fire), .data_hold(wr_hold)
    );

    hostbus_strobe #(.DW(1)) u_rd_edge (
        .clk(clk), .rst_n(rst_n), .strb_s(ctl_s[2]), .cs_s(ctl_s[0]),
        .data_s(ctl_s[3]), .fire(rd_fire), .data_hold(rd_hold)
    );

    assign cmd_fire = wr_fire && !wr_hold[HOST_W] && !cmd_busy;
    assign snd_fire = wr_fire &&  wr_hold[HOST_W];

    hostbus_cfg #(.BUSY_CYCLES(BUSY_CYCLES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire),
        .cmd_byte(wr_hold[BYTE_W-1:0]), .busy(cmd_busy),
        .port_dir_in(port_dir_in), .port_val(port_val)
    );

    // Register the transfer pulses and their payloads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid    <= 1'b0;
            cmd_data     <= '0;
            snd_wr_valid <= 1'b0;
            snd_wr_data  <= '0;
            snd_rd_pop   <= 1'b0;
        end else begin
            cmd_valid    <= cmd_fire;
            snd_wr_valid <= snd_fire;
            snd_rd_pop   <= rd_fire && rd_hold[0];
            if (cmd_fire) cmd_data <= wr_hold[BYTE_W-1:0];
            if (snd_fire) snd_wr_data <= wide_mode ? wr_hold[HOST_W-1:0]
                                                   : {{BYTE_W{1'b0}}, wr_hold[BYTE_W-1:0]};
        end
    end

    // Drive enables and read data from the live pin levels
    always_comb begin
        bus_oe_lo = !cs_n && !rd_n;
        bus_oe_hi = wide_mode ? (bus_oe_lo && dc_sel) : !port_dir_in;
        bus_out[BYTE_W-1:0]      = dc_sel ? snd_rd_data[BYTE_W-1:0] : {status_in, cmd_busy};
        bus_out[HOST_W-1:BYTE_W] = wide_mode ? snd_rd_data[HOST_W-1:BYTE_W] : port_val;
        xport_rd = (!wide_mode && port_dir_in) ? bus_s[HOST_W-1:BYTE_W] : '0;
    end
endmodule

// File: rtl/hostbus_port_chk.sv
// Property checker for hostbus_port, attached by bind.
module hostbus_port_chk import hostbus_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              wide_mode,
    input logic              cs_n,
    input logic              dc_sel,
    input logic [HOST_W-1:0] bus_out,
    input logic              bus_oe_lo,
    input logic              bus_oe_hi,
    input logic              cmd_valid,
    input logic              cmd_busy,
    input logic              snd_wr_valid,
    input logic              snd_rd_pop,
    input logic [BYTE_W-1:0] xport_rd
);
    p_cs_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !bus_oe_lo);

    p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_one_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && snd_wr_valid));

    p_hi_needs_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && bus_oe_hi) |-> bus_oe_lo);

    p_status_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_lo && !dc_sel) |-> (bus_out[0] == cmd_busy));

    p_busy_on_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_busy);

    p_cmd_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(cmd_busy));

    p_port_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && bus_oe_hi) |-> (xport_rd == '0));

    p_pop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snd_rd_pop |=> !snd_rd_pop);
endmodule

bind hostbus_port hostbus_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .cs_n(cs_n),
    .dc_sel(dc_sel), .bus_out(bus_out), .bus_oe_lo(bus_oe_lo),
    .bus_oe_hi(bus_oe_hi), .cmd_valid(cmd_valid), .cmd_busy(cmd_busy),
    .snd_wr_valid(snd_wr_valid), .snd_rd_pop(snd_rd_pop), .xport_rd(xport_rd)
);

// File: tb/hostbus_port_tb_top.sv
`timescale 1ns/1ps
module hostbus_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, dc_sel = 1'b0;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe_lo, bus_oe_hi;
    logic [6:0]  status_in = 7'h2B;
    logic [15:0] snd_rd_data = 16'hA55A;
    logic        cmd_valid, cmd_busy, snd_wr_valid, snd_rd_pop;
    logic [7:0]  cmd_data, xport_rd;
    logic [15:0] snd_wr_data;

    int checks = 0, errors = 0;
    int n_cmd, n_snd, n_busy, n_pop;
    logic [7:0]  got_cmd;
    logic [15:0] got_snd;

    always #2.5 clk = ~clk;

    hostbus_port dut_i (.*);

    // Fields: [34] wide, [33] dc, [32:17] bus, [16] expect command, [15:0] expected payload
    localparam logic [34:0] VEC [6] = '{
        {1'b1, 1'b0, 16'hFF34, 1'b1, 16'h0034},
        {1'b1, 1'b1, 16'hBEEF, 1'b0, 16'hBEEF},
        {1'b1, 1'b1, 16'h0001, 1'b0, 16'h0001},
        {1'b0, 1'b1, 16'h3C7A, 1'b0, 16'h007A},
        {1'b0, 1'b0, 16'h7712, 1'b1, 16'h0012},
        {1'b1, 1'b1, 16'h8000, 1'b0, 16'h8000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Count transfer pulses over a fixed window after a strobe release
    task automatic watch(input int cycles);
        n_cmd = 0; n_snd = 0; n_busy = 0; n_pop = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (cmd_valid)    begin n_cmd++; got_cmd = cmd_data; end
            if (snd_wr_valid) begin n_snd++; got_snd = snd_wr_data; end
            if (cmd_busy)     n_busy++;
            if (snd_rd_pop)   n_pop++;
        end
    endtask

    task automatic do_write(input logic cs, input logic dc, input logic [15:0] d);
        @(negedge clk); cs_n = cs; dc_sel = dc; bus_in = d;
        @(negedge clk); wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        watch(8);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(input logic cs, input logic dc);
        @(negedge clk); cs_n = cs; dc_sel = dc; rd_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_read();
        rd_n = 1'b1;
        watch(6);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state, sampled while reset is held
        check("R10 cmd_valid", cmd_valid, 0);
        check("R10 cmd_busy", cmd_busy, 0);
        check("R10 snd_wr_valid", snd_wr_valid, 0);
        wide_mode = 1'b0;
        @(negedge clk);
        check("R10 upper port value", bus_out[15:8], 8'h00);
        check("R10 upper lanes default output", bus_oe_hi, 1);
        wide_mode = 1'b1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: writes in both modes and both paths (R2, R3)
        foreach (VEC[k]) begin
            wide_mode = VEC[k][34];
            do_write(1'b0, VEC[k][33], VEC[k][32:17]);
            if (VEC[k][16]) begin
                check("R2 command pulse count", n_cmd, 1);
                check("R2 command byte", got_cmd, VEC[k][7:0]);
                check("R6 busy length", n_busy, 4);
                check("R3 no sound write on command", n_snd, 0);
            end else begin
                check("R3 sound pulse count", n_snd, 1);
                check("R3 sound word", got_snd, VEC[k][15:0]);
                check("R3 no command on sound write", n_cmd, 0);
            end
        end
        wide_mode = 1'b1;

        // R2 exact latency: cmd_valid 3 clocks after wr_n rises
        @(negedge clk); cs_n = 0; dc_sel = 0; bus_in = 16'h0055;
        @(negedge clk); wr_n = 0;
        repeat (3) @(negedge clk);
        wr_n = 1;
        repeat (2) @(negedge clk);
        check("R2 not yet at 2 clocks", cmd_valid, 0);
        @(negedge clk);
        check("R2 pulse at 3 clocks", cmd_valid, 1);
        cs_n = 1;
        repeat (8) @(negedge clk);

        // R1 chip select high: write and read ignored
        do_write(1'b1, 1'b0, 16'h00A1);
        check("R1 no command with cs high", n_cmd, 0);
        do_write(1'b1, 1'b1, 16'h1234);
        check("R1 no sound write with cs high", n_snd, 0);
        do_read(1'b1, 1'b1);
        check("R1 no low drive with cs high", bus_oe_lo, 0);
        end_read();
        check("R1 no pop with cs high", n_pop, 0);

        // R4 and R9 data read in wide mode
        do_read(1'b0, 1'b1);
        check("R4 low lanes enabled", bus_oe_lo, 1);
        check("R4 high lanes enabled on data read", bus_oe_hi, 1);
        check("R4 read data", bus_out, 16'hA55A);
        end_read();
        check("R9 one pop per data read", n_pop, 1);
        check("R4 lanes released", {bus_oe_hi, bus_oe_lo}, 2'b00);

        // R5 status read, idle then busy
        do_read(1'b0, 1'b0);
        check("R5 status idle", bus_out[7:0], 8'h56);
        check("R4 high lanes off on status read", bus_oe_hi, 0);
        end_read();
        check("R9 no pop on status read", n_pop, 0);

        // R6 second command inside busy window is dropped
        @(negedge clk); cs_n = 0; dc_sel = 0; bus_in = 16'h0011;
        @(negedge clk); wr_n = 0;
        repeat (3) @(negedge clk);
        wr_n = 1;
        repeat (3) @(negedge clk);
        bus_in = 16'h0022; wr_n = 0;
        @(negedge clk); wr_n = 1;
        rd_n = 0;
        @(negedge clk);
        check("R5 status shows busy", bus_out[0], 1);
        rd_n = 1;
        watch(8);
        check("R6 command while busy dropped", n_cmd, 0);
        check("R6 first command kept", cmd_data, 8'h11);
        cs_n = 1;
        repeat (4) @(negedge clk);

        // R7, R8 narrow-mode upper port
        wide_mode = 1'b0;
        do_write(1'b0, 1'b0, 16'h00C5);
        do_write(1'b0, 1'b0, 16'h00D9);
        check("R8 port value drives upper lanes", bus_out[15:8], 8'h95);
        check("R7 upper lanes output", bus_oe_hi, 1);
        check("R8 input view zero while output", xport_rd, 8'h00);
        bus_in = 16'h6E00;
        do_write(1'b0, 1'b0, 16'h6EA1);
        check("R7 upper lanes input", bus_oe_hi, 0);
        check("R8 input view", xport_rd, 8'h6E);
        wide_mode = 1'b1;
        @(negedge clk);
        check("R7 direction ignored in wide mode", bus_oe_hi, 0);
        check("R8 input view off in wide mode", xport_rd, 8'h00);
        wide_mode = 1'b0;
        do_write(1'b0, 1'b0, 16'h00A0);
        check("R7 upper lanes output again", bus_oe_hi, 1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule